// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block holds the data and direction state of a small group of general-purpose pins. Software reaches it over a simple register bus with a byte address, a read/write strobe and 32-bit data. The low 1 KB of the address space is a data window. In that window, address bits [9:2] act as a per-bit mask that picks which data bits an access touches. Software can therefore set, clear or sample a single pin with one store or one load, and never needs a read-modify-write sequence.

Each pin has one direction bit. A pin configured as an output drives its stored data bit onto `pin_out`. A pin configured as an input lets its external level flow into the data register through a two-flop synchronizer, and drives a 1 on `pin_out` so that the line floats high. The direction register sits directly above the data window. Every other address reads as zero and ignores writes.

The bus side is a two-state machine:
- `ST_IDLE` is the waiting state. A read request moves it to `ST_RESP`. A write, or no request, keeps it in `ST_IDLE`.
- `ST_RESP` presents the registered read data with `bus_rvalid` high for one cycle. From there, a new read request keeps it in `ST_RESP`; otherwise it returns to `ST_IDLE`.

Writes complete on the edge that accepts them.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, the data and direction registers are 0, so every pin is an input and `pin_out` is all ones.
- R2: The direction register is at byte offset 0x400. A bit of 1 makes that pin an output. Only the low 8 bits of a write are kept, and reads return bits 31:8 as 0.
- R3: A read at an offset below 0x400 returns the data register ANDed with address bits [9:2], with bit i of the mask at address bit i+2. All other bits read as 0.
- R4: A write at an offset below 0x400 changes only those data bits that are both set in the address mask and configured as outputs. All other data bits keep their value.
- R5: `pin_out` bit i equals data bit i when direction bit i is 1, and equals 1 when direction bit i is 0.
- R6: The data bit of an input pin takes the level of `pin_in` through two synchronizer flops. After a change on `pin_in` made between clock edges, reads captured on the first three rising edges still return the old value, and a read captured on the fourth returns the new value. Changes on `pin_in` for output pins leave their data bits unchanged.
- R7: A read request accepted on a rising edge gives `bus_rvalid` high with valid `bus_rdata` during the following cycle. A write request never raises `bus_rvalid`.
- R8: Offsets at or above 0x404 read as 0, and writes to them change neither data nor direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request, one per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read response strobe, one cycle after a read request |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Pin drive levels |

## Verification
The bench builds the block with its defaults: 8 pins, a 12-bit address and 32-bit data. With 8 pins the address mask has only 256 values, so the bench sweeps every mask for reads against a known data pattern. It also sweeps every mask for writes under four direction patterns (all inputs, all outputs and two mixed ones), comparing data and `pin_out` with an arithmetic model after each store. Directed sequences then cover the synchronizer latency edge by edge, output pins ignoring `pin_in`, and addresses outside the data window and the direction register.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_t;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] s1_q;
    logic [WIDTH-1:0] s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    assign dout = s2_q;

    // R6: two-stage chain, each stage one cycle behind the previous one
    assert_sync_stage1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (s1_q == $past(din)));
    assert_sync_stage2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (s2_q == $past(s1_q)));

endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_mask_pkg::*;
#(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NPINS-1:0]  data_q,
    input  logic [NPINS-1:0]  dir_q,
    output logic              wr_data_en,
    output logic              wr_dir_en,
    output logic [NPINS-1:0]  wmask,
    output logic [NPINS-1:0]  wbits,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid
);

    localparam int MASK_LSB = 2;
    localparam int WIN_MSB  = NPINS + MASK_LSB;
    localparam int WORD_W   = ADDR_W - MASK_LSB;
    localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(1) << NPINS;
    localparam int PAD_W    = DATA_W - NPINS;

    bus_state_t state_q, state_d;
    logic              in_win;
    logic              at_dir;
    logic              rd_req;
    logic [NPINS-1:0]  amask;
    logic [NPINS-1:0]  rd_bits;
    logic [DATA_W-1:0] rdata_q;

    assign in_win = (bus_addr[ADDR_W-1:WIN_MSB] == '0);
    assign at_dir = (bus_addr[ADDR_W-1:MASK_LSB] == DIR_WORD);
    assign amask  = bus_addr[WIN_MSB-1:MASK_LSB];
    assign rd_req = bus_req && !bus_we;

    assign wr_data_en = bus_req && bus_we && in_win;
    assign wr_dir_en  = bus_req && bus_we && at_dir;
    assign wmask      = amask;
    assign wbits      = bus_wdata[NPINS-1:0];

    always_comb begin
        if (in_win)      rd_bits = data_q & amask;
        else if (at_dir) rd_bits = dir_q;
        else             rd_bits = '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rd_req) state_d = ST_RESP;
            ST_RESP: if (!rd_req) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= {{PAD_W{1'b0}}, rd_bits};
    end

    always_comb begin
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rdata_q;
            end
            default: ;
        endcase
    end

    // R7: a response follows every read request, and only read requests
    assert_rd_resp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);
    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !bus_rvalid);
    // R3: a window read never returns bits outside the address mask
    assert_rd_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && in_win) |=> ((bus_rdata & ~{{PAD_W{1'b0}}, $past(amask)}) == '0));

endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data_en,
    input  logic             wr_dir_en,
    input  logic [NPINS-1:0] wmask,
    input  logic [NPINS-1:0] wbits,
    input  logic [NPINS-1:0] sync_in,
    output logic [NPINS-1:0] data_q,
    output logic [NPINS-1:0] dir_q
);

    logic [NPINS-1:0] data_d;
    logic [NPINS-1:0] wsel;

    assign wsel = wmask & dir_q;

    always_comb begin
        data_d = (data_q & dir_q) | (sync_in & ~dir_q);
        if (wr_data_en) data_d = (data_d & ~wsel) | (wbits & wsel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            data_q <= data_d;
            if (wr_dir_en) dir_q <= wbits;
        end
    end

    // R4: a store leaves unselected output bits alone
    assert_wr_confined_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_en |=> (((data_q ^ $past(data_q)) & $past(dir_q) & ~$past(wmask)) == '0));
    // R4: without a store, output bits hold
    assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_data_en |=> (((data_q ^ $past(data_q)) & $past(dir_q)) == '0));
    // R6: input bits take the synchronized level
    assert_in_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((data_q ^ $past(sync_in)) & ~$past(dir_q)) == '0));
    // R2: direction changes only on a direction store
    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir_en |=> $stable(dir_q));

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
    parameter int NPINS  = 8,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out
);

    logic [NPINS-1:0] sync_in;
    logic [NPINS-1:0] data_q;
    logic [NPINS-1:0] dir_q;
    logic             wr_data_en;
    logic             wr_dir_en;
    logic [NPINS-1:0] wmask;
    logic [NPINS-1:0] wbits;

    gpio_sync #(.WIDTH(NPINS)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (sync_in)
    );

    gpio_bus_fsm #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .wr_data_en(wr_data_en),
        .wr_dir_en (wr_dir_en),
        .wmask     (wmask),
        .wbits     (wbits),
        .bus_rdata (bus_rdata),
        .bus_rvalid(bus_rvalid)
    );

    gpio_pin_regs #(.NPINS(NPINS)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_data_en(wr_data_en),
        .wr_dir_en (wr_dir_en),
        .wmask     (wmask),
        .wbits     (wbits),
        .sync_in   (sync_in),
        .data_q    (data_q),
        .dir_q     (dir_q)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign pin_out[i] = dir_q[i] ? data_q[i] : 1'b1;
    end

    // R5: an input pin always floats high
    assert_float_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_out[0]) |-> dir_q[0]);
    // R1: the first cycle out of reset sees an all-ones drive
    assert_reset_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_out == '1));

endmodule

// File: tb/gpio_mask_port_tb.sv
`timescale 1ns/1ps
module gpio_mask_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [7:0] model = '0;
    logic [7:0] dir_m = '0;
    logic [31:0] rd;

    always #2.5 clk = ~clk;

    gpio_mask_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        check("R7 write gives no rvalid", {31'b0, bus_rvalid}, 32'd0);
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        check("R7 rvalid after read", {31'b0, bus_rvalid}, 32'd1);
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        model = (model & dir_m) | (pin_in & ~dir_m);
    endtask

    task automatic set_dir(input logic [7:0] d);
        bus_write(12'h400, {24'hABCDEF, d});
        dir_m = d;
        model = (model & dir_m) | (pin_in & ~dir_m);
        bus_read(12'h400, rd);
        check("R2 direction readback", rd, {24'h0, d});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 pin_out after reset", {24'h0, pin_out}, 32'h0000_00FF);
        bus_read(12'h400, rd);
        check("R1 direction after reset", rd, 32'h0);
        bus_read(12'h3FC, rd);
        check("R1 data after reset", rd, 32'h0);

        // R3: build a data pattern, then sweep every read mask
        set_dir(8'hFF);
        bus_write(12'h3FC, 32'hFFFF_FF5A);
        model = 8'h5A;
        pin_in = 8'hC3;
        set_dir(8'h0F);
        settle();
        check("R3 pattern sanity", {24'h0, model}, 32'h0000_00CA);
        for (int m = 0; m < 256; m++) begin
            bus_read(12'(m << 2), rd);
            check("R3 masked read", rd, {24'h0, model & 8'(m)});
        end

        // R4/R5: every write mask under four direction patterns
        pin_in = 8'h96;
        settle();
        for (int k = 0; k < 4; k++) begin
            logic [7:0] dv;
            case (k)
                0: dv = 8'h00;
                1: dv = 8'hFF;
                2: dv = 8'h3C;
                default: dv = 8'hA5;
            endcase
            set_dir(dv);
            for (int m = 0; m < 256; m++) begin
                logic [7:0] wv;
                logic [7:0] sel;
                wv = 8'((m * 37 + 11 + k * 5) & 8'hFF);
                sel = 8'(m) & dir_m;
                bus_write(12'(m << 2), {24'hA5A5A5, wv});
                model = (model & ~sel) | (wv & sel);
                check("R5 pin drive", {24'h0, pin_out}, {24'h0, model | ~dir_m});
                bus_read(12'h3FC, rd);
                check("R4 masked write", rd, {24'h0, model});
            end
        end

        // R6: latency of the synchronizer, and output pins ignore pin_in
        set_dir(8'hF0);
        pin_in = 8'h96;
        settle();
        begin
            logic [7:0] old_v;
            old_v = model;
            pin_in = 8'h69;
            for (int e = 1; e <= 3; e++) begin
                bus_read(12'h3FC, rd);
                check("R6 old value before sync", rd, {24'h0, old_v});
            end
            bus_read(12'h3FC, rd);
            check("R6 new value after sync", rd, {24'h0, (old_v & 8'hF0) | 8'h09});
            model = (old_v & 8'hF0) | 8'h09;
            settle();
            bus_read(12'h3FC, rd);
            check("R6 output pins ignore pin_in", rd, {24'h0, model});
        end

        // R8: addresses outside the window and the direction register
        begin
            logic [11:0] bad [4];
            bad[0] = 12'h404; bad[1] = 12'h408; bad[2] = 12'h800; bad[3] = 12'hFFC;
            for (int b = 0; b < 4; b++) begin
                bus_write(bad[b], 32'hFFFF_FFFF);
                bus_read(bad[b], rd);
                check("R8 unmapped reads zero", rd, 32'h0);
            end
            bus_read(12'h400, rd);
            check("R8 direction untouched", rd, {24'h0, dir_m});
            bus_read(12'h3FC, rd);
            check("R8 data untouched", rd, {24'h0, model});
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule